// File: doc/BRIEF.md
# Pipelined Masked SRAM Wrapper

The block wraps a 256-word by 8-bit single-port synchronous memory behind a narrow pin interface. That interface has a 6-bit address, an active-low write select, an 8-bit write-data bus and an 8-bit read-data bus. A single register stage sits between the pins and the memory port. A second single register stage sits between the memory port and the read-data pins. Access from the pins therefore has a fixed pipeline depth.

The external address reaches only a 64-word window of the array. The high-order bits of the memory address are tied to a parameterised constant, which by default places the window at the top of the array. The inner memory port has the following active-low controls:
- a chip enable,
- a global write enable,
- a per-bit write mask.

The wrapper always drives the mask fully enabled, so a write from the pins replaces the whole byte.

Each reset starts a clear sweep. A counter writes zero to every one of the 256 words, one word per clock. A busy flag stays high for the length of the sweep, and writes from the pins are dropped until the flag falls.

Top module: `sram_wrap`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o` reads 1 and `rdata_o` reads 0. The inner chip enable is held high (inactive) throughout reset.
- R2: After reset is released, `busy_o` stays high for exactly 256 rising edges (2^MEM_AW) and then reads 0 until the next reset.
- R3: After the sweep, every reachable word reads 0x00, including words that held nonzero data before the reset.
- R4: A cycle with `wr_n_i` low writes the full byte on `wdata_i` to the word selected by `addr_i`.
- R5: A read presented before rising edge k (`wr_n_i` high) appears on `rdata_o` after rising edge k+2. Back-to-back reads can therefore be issued every cycle.
- R6: During write cycles the memory read register keeps its last value, so `rdata_o` keeps showing the data of the most recent read.
- R7: A write presented in a cycle where `busy_o` is 1 is dropped and leaves the memory unchanged.
- R8: Each of the 64 external addresses selects its own word. The word is array index {TIE, addr_i}, with TIE all ones by default. Writing one address leaves the other 63 unchanged.
- R9: On the inner port, a cycle with the chip enable high (inactive) performs neither a write nor a read. Stored data and the read register are both kept.
- R10: On the inner port during a write, only the data bits whose write mask bit is 0 are updated. Bits with mask 1 keep their old value.
- R11: A read issued in the cycle right after a write to the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| addr_i | input | 6 | Word address within the reachable window |
| wr_n_i | input | 1 | Low: write cycle; high: read cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, two cycles after the address |
| busy_o | output | 1 | High while the clear sweep runs |

## Verification
A wrong sweep counter or busy flag shows up at the ports in two ways: `busy_o` falls on the wrong cycle, or a word still reads nonzero once the flag is low. In both cases the fault is visible within one 256-cycle sweep and a 64-address read-out. A wrong address map or broken write path shows up as a word that reads back a pattern other than the one written. It can also show up as one write that disturbs a neighbour. The fault appears exactly two cycles after the read that hits that word, because the read latency is fixed. A read register that updates during writes changes `rdata_o` in the cycle after such a write reaches the output stage.

// File: rtl/sram_wrap_pkg.sv
package sram_wrap_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_MEM_AW = 8;
  localparam int DEF_EXT_AW = 6;
endpackage

// File: rtl/sram_core.sv
// Single-port synchronous memory with active-low enable, write enable and bit mask.
module sram_core #(
  parameter int DATA_W = sram_wrap_pkg::DEF_DATA_W,
  parameter int ADDR_W = sram_wrap_pkg::DEF_MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cen_n,
  input  logic              gwen_n,
  input  logic [DATA_W-1:0] wen_n,
  input  logic [ADDR_W-1:0] a,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: array has no reset so it can map onto block RAM.
  always_ff @(posedge clk) begin
    if (!cen_n && !gwen_n) begin
      for (int b = 0; b < DATA_W; b++) begin
        if (!wen_n[b]) mem[a][b] <= d[b];
      end
    end
  end

  // Read register: loads only on an enabled read cycle.
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (!cen_n && gwen_n) q <= mem[a];
  end
endmodule

// File: rtl/sram_clear_seq.sv
// Post-reset sweep: one word per clock, busy until the last address is written.
module sram_clear_seq #(
  parameter int ADDR_W = sram_wrap_pkg::DEF_MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  output logic              busy,
  output logic [ADDR_W-1:0] cnt
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_in_stage.sv
// Input register stage; writes offered while busy are dropped here.
module sram_in_stage #(
  parameter int DATA_W = sram_wrap_pkg::DEF_DATA_W,
  parameter int EXT_AW = sram_wrap_pkg::DEF_EXT_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [EXT_AW-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [EXT_AW-1:0] addr_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
    end else begin
      addr_q <= addr_i;
      wr_q   <= ~wr_n_i & ~busy;
      data_q <= wdata_i;
    end
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage #(
  parameter int DATA_W = sram_wrap_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/sram_wrap.sv
module sram_wrap #(
  parameter int DATA_W = sram_wrap_pkg::DEF_DATA_W,
  parameter int MEM_AW = sram_wrap_pkg::DEF_MEM_AW,
  parameter int EXT_AW = sram_wrap_pkg::DEF_EXT_AW,
  parameter logic [MEM_AW-EXT_AW-1:0] TIE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [EXT_AW-1:0] addr_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  logic [EXT_AW-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] data_q;
  logic [MEM_AW-1:0] sweep_cnt;
  logic              core_cen_n;
  logic              core_gwen_n;
  logic [DATA_W-1:0] core_wen_n;
  logic [MEM_AW-1:0] core_a;
  logic [DATA_W-1:0] core_d;
  logic [DATA_W-1:0] core_q;

  sram_clear_seq #(.ADDR_W(MEM_AW)) u_seq (
    .clk(clk), .rst(rst), .busy(busy_o), .cnt(sweep_cnt)
  );

  sram_in_stage #(.DATA_W(DATA_W), .EXT_AW(EXT_AW)) u_in (
    .clk(clk), .rst(rst), .busy(busy_o),
    .addr_i(addr_i), .wr_n_i(wr_n_i), .wdata_i(wdata_i),
    .addr_q(addr_q), .wr_q(wr_q), .data_q(data_q)
  );

  // Port selection: sweep owns the memory while busy, else the registered request.
  always_comb begin
    core_cen_n = rst;
    core_wen_n = '0;
    if (busy_o) begin
      core_gwen_n = 1'b0;
      core_a      = sweep_cnt;
      core_d      = '0;
    end else begin
      core_gwen_n = ~wr_q;
      core_a      = {TIE, addr_q};
      core_d      = data_q;
    end
  end

  sram_core #(.DATA_W(DATA_W), .ADDR_W(MEM_AW)) u_mem (
    .clk(clk), .rst(rst), .cen_n(core_cen_n), .gwen_n(core_gwen_n),
    .wen_n(core_wen_n), .a(core_a), .d(core_d), .q(core_q)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .d(core_q), .q(rdata_o)
  );
endmodule

// File: rtl/sram_wrap_chk.sv
module sram_wrap_chk #(
  parameter int DATA_W = 8,
  parameter int MEM_AW = 8,
  parameter int EXT_AW = 6,
  parameter logic [MEM_AW-EXT_AW-1:0] TIE = '1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              core_cen_n,
  input logic              core_gwen_n,
  input logic [DATA_W-1:0] core_wen_n,
  input logic [MEM_AW-1:0] core_a,
  input logic [DATA_W-1:0] core_d,
  input logic [MEM_AW-1:0] sweep_cnt
);
  localparam logic [MEM_AW-1:0] LAST = '1;

  // R1: memory disabled while reset is applied
  always_comb begin
    if (rst) assert_cen_hi_in_reset_R1: assert (core_cen_n);
  end

  // R1: busy raised by reset
  assert_busy_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> busy_o);

  // R2: busy drops only after the last sweep address
  assert_busy_fall_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(sweep_cnt) == LAST);

  // R3: sweep writes zero through the full mask
  assert_sweep_writes_zero_R3: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (!core_cen_n && !core_gwen_n && core_wen_n == '0 && core_d == '0));

  // R3: sweep addresses advance by one each cycle
  assert_sweep_step_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o) && !$past(rst)) |-> core_a == $past(core_a) + 1'b1);

  // R8: user accesses stay inside the reachable window
  assert_window_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> core_a[MEM_AW-1:EXT_AW] == TIE);

  // R6: output holds across a write reaching the output stage
  assert_hold_on_write_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !core_gwen_n && !$past(rst)) |=> $stable(rdata_o) || $past(rst));
endmodule

bind sram_wrap sram_wrap_chk #(
  .DATA_W(DATA_W), .MEM_AW(MEM_AW), .EXT_AW(EXT_AW), .TIE(TIE)
) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .rdata_o(rdata_o),
  .core_cen_n(core_cen_n), .core_gwen_n(core_gwen_n), .core_wen_n(core_wen_n),
  .core_a(core_a), .core_d(core_d), .sweep_cnt(sweep_cnt)
);

// File: tb/sim_sram_wrap.sv
module sim_sram_wrap;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] addr_i = '0;
  logic       wr_n_i = 1'b1;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       busy_o;

  // direct inner-port instance
  logic       c_cen_n = 1'b1;
  logic       c_gwen_n = 1'b1;
  logic [7:0] c_wen_n = '1;
  logic [7:0] c_a = '0;
  logic [7:0] c_d = '0;
  logic [7:0] c_q;

  int total = 0;
  int bad = 0;
  logic [7:0] model [64];

  always #2 clk = ~clk;

  sram_wrap u0 (
    .clk(clk), .rst(rst), .addr_i(addr_i), .wr_n_i(wr_n_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .busy_o(busy_o)
  );

  sram_core u1 (
    .clk(clk), .rst(rst), .cen_n(c_cen_n), .gwen_n(c_gwen_n),
    .wen_n(c_wen_n), .a(c_a), .d(c_d), .q(c_q)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy_o && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(req, n, 256);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wr_n_i = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic write_all(input int mode);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      addr_i = 6'(i);
      wdata_i = (mode == 0) ? 8'((i * 37 + 11) & 255) : (8'(i) ^ 8'h5A) ^ 8'hFF;
      wr_n_i = 1'b0;
      model[i] = wdata_i;
    end
    @(negedge clk);
    wr_n_i = 1'b1;
  endtask

  // Pipelined read of all 64 words: result of read i sampled three negedges later.
  task automatic read_all(input string req, input int zero);
    for (int i = 0; i < 67; i++) begin
      @(negedge clk);
      if (i >= 3) check(req, rdata_o, zero ? 0 : model[i-3]);
      if (i < 64) begin
        addr_i = 6'(i);
        wr_n_i = 1'b1;
      end
    end
  endtask

  task automatic read_one(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    addr_i = a;
    wr_n_i = 1'b1;
    repeat (3) @(negedge clk);
    v = rdata_o;
  endtask

  initial begin
    logic [7:0] v;
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 busy in reset", busy_o, 1);
    check("R1 rdata in reset", rdata_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after release", busy_o, 1);
    check("R1 rdata after release", rdata_o, 0);
    // R2 sweep length (one cycle already elapsed)
    begin
      int n = 1;
      while (busy_o && n < 1000) begin
        @(negedge clk);
        n++;
      end
      check("R2 sweep length", n, 256);
    end
    // R3 cleared contents
    read_all("R3 clear after first reset", 1);
    // R4 / R5 / R8 exhaustive pattern writes and pipelined reads
    write_all(0);
    read_all("R4 R5 R8 pattern A", 0);
    write_all(1);
    read_all("R4 R5 R8 pattern B", 0);
    // R8 single write leaves neighbours unchanged
    @(negedge clk);
    addr_i = 6'd20; wdata_i = 8'hC3; wr_n_i = 1'b0; model[20] = 8'hC3;
    @(negedge clk);
    wr_n_i = 1'b1;
    read_all("R8 isolation", 0);
    // R11 read right after write
    @(negedge clk);
    addr_i = 6'd9; wdata_i = 8'h3C; wr_n_i = 1'b0; model[9] = 8'h3C;
    @(negedge clk);
    wr_n_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 read after write", rdata_o, 8'h3C);
    // R6 hold during writes
    read_one(6'd0, v);
    check("R6 read before writes", v, model[0]);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R6 hold during writes", rdata_o, model[0]);
      addr_i = 6'(40 + i); wdata_i = 8'(i * 17); wr_n_i = 1'b0;
      model[40 + i] = 8'(i * 17);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wr_n_i = 1'b1;
      check("R6 hold tail", rdata_o, model[0]);
    end
    read_one(6'd43, v);
    check("R6 written word landed", v, 8'd51);
    // R3 clear after nonzero data, R7 writes dropped while busy
    do_reset();
    @(negedge clk);
    addr_i = 6'd5; wdata_i = 8'hAA; wr_n_i = 1'b0;
    begin
      int n = 0;
      while (busy_o && n < 1000) begin
        @(negedge clk);
        n++;
      end
      check("R2 sweep length again", n, 255);
    end
    wr_n_i = 1'b1;
    read_one(6'd5, v);
    check("R7 write during busy dropped", v, 0);
    read_all("R3 clear after second reset", 1);
    // R9 / R10 on the inner port
    @(negedge clk);
    c_cen_n = 0; c_gwen_n = 0; c_wen_n = 8'h00; c_a = 8'd3; c_d = 8'hFF;
    @(negedge clk);
    c_wen_n = 8'hF0; c_d = 8'h00;
    @(negedge clk);
    c_gwen_n = 1; c_wen_n = 8'hFF;
    @(negedge clk);
    check("R10 mask low nibble", c_q, 8'hF0);
    c_gwen_n = 0; c_wen_n = 8'h0F; c_d = 8'h3C;
    @(negedge clk);
    c_gwen_n = 1;
    @(negedge clk);
    check("R10 mask high nibble", c_q, 8'h30);
    c_cen_n = 1; c_gwen_n = 0; c_wen_n = 8'h00; c_d = 8'h55;
    @(negedge clk);
    c_gwen_n = 1; c_a = 8'd7;
    @(negedge clk);
    check("R9 q held while disabled", c_q, 8'h30);
    c_cen_n = 0; c_a = 8'd3;
    @(negedge clk);
    check("R9 write blocked while disabled", c_q, 8'h30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule